// File: doc/BRIEF.md
# RTC Alarm Comparison Unit

This block stores the alarm settings of a real-time clock and raises the alarm flags that software polls or routes onward. It keeps an 8-bit subsecond reload value, which it hands to the clock core, and a time-of-day alarm held in a 16-bit low register and an 8-bit high register. Only the low four bits of the high register join the 16 low bits to form the 20-bit alarm value.

The time-of-day compare is not continuous. The clock core pulses a rollover strobe once per second when its subsecond counter wraps. At that pulse, if both the alarm and the clock are enabled and the 20 low bits of the seconds count equal the alarm value, a sticky flag is set. A separate sticky flag records every subsecond autoreload that the core reports.

The alarm registers are locked while the clock core is busy, or while both the alarm and the clock are enabled. A write attempted while they are locked changes nothing and sets a sticky error bit. All three flags are cleared by writing ones to a status word.

Top module: `rtc_alarm_unit`

## Requirements
- R1: After reset, every alarm register reads zero, `sub_reload_val` is zero, and all three flags are 0.
- R2: Register addresses are 0 for the subsecond reload (8 bits), 1 for the alarm low word (16 bits) and 2 for the alarm high byte (8 bits). An accepted write stores the low bits of `reg_wdata`, and a read returns every stored bit zero-extended to 16 bits, including all 8 bits of the high byte.
- R3: A write to address 0, 1 or 2 is accepted only when `clk_busy` is 0 and at least one of `alarm_en` and `clock_en` is 0. Any other such write leaves the register unchanged and sets `wr_err` on the next clock edge.
- R4: When `sub_roll` is high, `alarm_en` and `clock_en` are both 1, and `secs_low` equals {high[3:0], low[15:0]}, `tod_flag` is 1 from the next clock edge on.
- R5: Bits [7:4] of the high byte have no effect on the compare.
- R6: `tod_flag` never sets in a cycle without `sub_roll`, or while `alarm_en` or `clock_en` is 0, even when the values are equal.
- R7: A `sub_reload` pulse sets `sub_flag` at the next edge, and `sub_reload_val` always equals the stored subsecond register.
- R8: Address 3 is the status word: bit 0 is `tod_flag`, bit 1 is `sub_flag`, bit 2 is `wr_err`. Writing a 1 to a bit clears that flag, and a write to this address is never locked. When a set and a clear of the same flag fall in one cycle, the flag ends up set.
- R9: `wr_err` stays set until it is cleared through status bit 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for `reg_addr` (combinational) |
| secs_low | input | 20 | Low 20 bits of the running seconds count |
| sub_roll | input | 1 | One-cycle pulse when the subsecond counter wraps |
| sub_reload | input | 1 | One-cycle pulse when the subsecond alarm reloads |
| clk_busy | input | 1 | Clock core busy |
| alarm_en | input | 1 | Time-of-day alarm enable |
| clock_en | input | 1 | Clock running enable |
| sub_reload_val | output | 8 | Subsecond reload value for the clock core |
| tod_flag | output | 1 | Sticky time-of-day alarm flag |
| sub_flag | output | 1 | Sticky subsecond alarm flag |
| wr_err | output | 1 | Sticky blocked-write flag |

## Verification
Two events can land in the same cycle: a rollover that produces a time-of-day match, and a write of one to status bit 0 that clears that same flag. The bench sets the flag with an earlier matching rollover. It then drives the rollover pulse and the clearing write at the same falling edge, and requires the flag to read 1 after the next rising edge. A second case applies the clear alone, and then a clear together with a rollover whose value does not match, and expects 0 after each. Together these cases show that the priority decides only the cycle where the two events meet.

// File: rtl/rtc_alarm_pkg.sv
package rtc_alarm_pkg;
  localparam int SUB_W   = 8;
  localparam int LO_W    = 16;
  localparam int HI_W    = 8;
  localparam int HI_USED = 4;
  localparam int TOD_W   = LO_W + HI_USED;
  localparam int DATA_W  = 16;
  localparam int ADDR_W  = 2;
  localparam int NFLAG   = 3;

  typedef enum logic [ADDR_W-1:0] {
    SEL_SUB  = 2'd0,
    SEL_TLO  = 2'd1,
    SEL_THI  = 2'd2,
    SEL_STAT = 2'd3
  } reg_sel_e;

  // flag positions in the status word
  localparam int FL_TOD = 0;
  localparam int FL_SUB = 1;
  localparam int FL_ERR = 2;

  function automatic logic [TOD_W-1:0] tod_value(input logic [HI_W-1:0] hi,
                                                 input logic [LO_W-1:0] lo);
    return {hi[HI_USED-1:0], lo};
  endfunction

  function automatic logic regs_open(input logic busy, input logic ae,
                                     input logic ce);
    return !busy && !(ae && ce);
  endfunction
endpackage

// File: rtl/rtc_alarm_regs.sv
module rtc_alarm_regs
  import rtc_alarm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              open,
  output logic [SUB_W-1:0]  sub_q,
  output logic [LO_W-1:0]   lo_q,
  output logic [HI_W-1:0]   hi_q,
  output logic              blocked
);
  logic alarm_sel;
  logic accept;

  assign alarm_sel = wr && (reg_sel_e'(addr) != SEL_STAT);
  assign accept    = alarm_sel && open;
  assign blocked   = alarm_sel && !open;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sub_q <= '0;
      lo_q  <= '0;
      hi_q  <= '0;
    end else if (accept) begin
      case (reg_sel_e'(addr))
        SEL_SUB: sub_q <= wdata[SUB_W-1:0];
        SEL_TLO: lo_q  <= wdata[LO_W-1:0];
        SEL_THI: hi_q  <= wdata[HI_W-1:0];
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/rtc_tod_match.sv
module rtc_tod_match
  import rtc_alarm_pkg::*;
(
  input  logic             roll,
  input  logic             ae,
  input  logic             ce,
  input  logic [TOD_W-1:0] secs,
  input  logic [HI_W-1:0]  hi,
  input  logic [LO_W-1:0]  lo,
  output logic             hit
);
  logic equal;
  assign equal = (secs == tod_value(hi, lo));
  assign hit   = roll && ae && ce && equal;
endmodule

// File: rtl/rtc_sticky_flag.sv
module rtc_sticky_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   q <= 1'b0;
    else if (set) q <= 1'b1;
    else if (clr) q <= 1'b0;
  end
endmodule

// File: rtl/rtc_alarm_unit.sv
module rtc_alarm_unit
  import rtc_alarm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic [TOD_W-1:0]  secs_low,
  input  logic              sub_roll,
  input  logic              sub_reload,
  input  logic              clk_busy,
  input  logic              alarm_en,
  input  logic              clock_en,
  output logic [SUB_W-1:0]  sub_reload_val,
  output logic              tod_flag,
  output logic              sub_flag,
  output logic              wr_err
);
  logic [SUB_W-1:0] sub_q;
  logic [LO_W-1:0]  lo_q;
  logic [HI_W-1:0]  hi_q;
  logic             wr_open;
  logic             wr_blocked;
  logic             tod_hit;
  logic             stat_wr;
  logic [NFLAG-1:0] flag_set;
  logic [NFLAG-1:0] flag_clr;
  logic [NFLAG-1:0] flag_q;

  assign wr_open = regs_open(clk_busy, alarm_en, clock_en);

  rtc_alarm_regs u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr      (reg_wr),
    .addr    (reg_addr),
    .wdata   (reg_wdata),
    .open    (wr_open),
    .sub_q   (sub_q),
    .lo_q    (lo_q),
    .hi_q    (hi_q),
    .blocked (wr_blocked)
  );

  rtc_tod_match u_match (
    .roll (sub_roll),
    .ae   (alarm_en),
    .ce   (clock_en),
    .secs (secs_low),
    .hi   (hi_q),
    .lo   (lo_q),
    .hit  (tod_hit)
  );

  assign stat_wr = reg_wr && (reg_sel_e'(reg_addr) == SEL_STAT);

  always_comb begin
    flag_set         = '0;
    flag_set[FL_TOD] = tod_hit;
    flag_set[FL_SUB] = sub_reload;
    flag_set[FL_ERR] = wr_blocked;
    flag_clr         = stat_wr ? reg_wdata[NFLAG-1:0] : '0;
  end

  for (genvar i = 0; i < NFLAG; i++) begin : g_flag
    rtc_sticky_flag u_flag (
      .clk   (clk),
      .rst_n (rst_n),
      .set   (flag_set[i]),
      .clr   (flag_clr[i]),
      .q     (flag_q[i])
    );
  end

  assign tod_flag       = flag_q[FL_TOD];
  assign sub_flag       = flag_q[FL_SUB];
  assign wr_err         = flag_q[FL_ERR];
  assign sub_reload_val = sub_q;

  always_comb begin
    case (reg_sel_e'(reg_addr))
      SEL_SUB:  reg_rdata = DATA_W'(sub_q);
      SEL_TLO:  reg_rdata = DATA_W'(lo_q);
      SEL_THI:  reg_rdata = DATA_W'(hi_q);
      default:  reg_rdata = DATA_W'(flag_q);
    endcase
  end
endmodule

// File: rtl/rtc_alarm_chk.sv
module rtc_alarm_chk
  import rtc_alarm_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [DATA_W-1:0] reg_wdata,
  input logic [TOD_W-1:0]  secs_low,
  input logic              sub_roll,
  input logic              sub_reload,
  input logic              alarm_en,
  input logic              clock_en,
  input logic              tod_flag,
  input logic              sub_flag,
  input logic              wr_err,
  input logic              wr_blocked,
  input logic [SUB_W-1:0]  sub_q,
  input logic [LO_W-1:0]   lo_q,
  input logic [HI_W-1:0]   hi_q
);
  // R3
  wr_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_blocked |=> (wr_err && $stable(sub_q) && $stable(lo_q) && $stable(hi_q)));

  // R4
  tod_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sub_roll && alarm_en && clock_en &&
     secs_low == {hi_q[HI_USED-1:0], lo_q}) |=> tod_flag);

  // R6
  tod_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sub_roll && !tod_flag) |=> !tod_flag);

  // R7
  sub_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sub_reload |=> sub_flag);

  // R9
  err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_err && !(reg_wr && reg_addr == 2'd3 && reg_wdata[2])) |=> wr_err);
endmodule

bind rtc_alarm_unit rtc_alarm_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .reg_wr     (reg_wr),
  .reg_addr   (reg_addr),
  .reg_wdata  (reg_wdata),
  .secs_low   (secs_low),
  .sub_roll   (sub_roll),
  .sub_reload (sub_reload),
  .alarm_en   (alarm_en),
  .clock_en   (clock_en),
  .tod_flag   (tod_flag),
  .sub_flag   (sub_flag),
  .wr_err     (wr_err),
  .wr_blocked (wr_blocked),
  .sub_q      (sub_q),
  .lo_q       (lo_q),
  .hi_q       (hi_q)
);

// File: tb/tb_rtc_alarm_unit.sv
`timescale 1ns/1ps
module tb_rtc_alarm_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [15:0] reg_wdata = 16'd0;
  logic [15:0] reg_rdata;
  logic [19:0] secs_low = 20'd0;
  logic        sub_roll = 1'b0;
  logic        sub_reload = 1'b0;
  logic        clk_busy = 1'b0;
  logic        alarm_en = 1'b0;
  logic        clock_en = 1'b0;
  logic [7:0]  sub_reload_val;
  logic        tod_flag;
  logic        sub_flag;
  logic        wr_err;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  rtc_alarm_unit dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .secs_low(secs_low),
    .sub_roll(sub_roll), .sub_reload(sub_reload), .clk_busy(clk_busy),
    .alarm_en(alarm_en), .clock_en(clock_en), .sub_reload_val(sub_reload_val),
    .tod_flag(tod_flag), .sub_flag(sub_flag), .wr_err(wr_err)
  );

  // {high byte, low word, seconds, alarm_en, clock_en, expected flag}
  localparam logic [46:0] VEC [7] = '{
    {8'h00, 16'h1234, 20'h01234, 1'b1, 1'b1, 1'b1},
    {8'hF5, 16'hABCD, 20'h5ABCD, 1'b1, 1'b1, 1'b1},
    {8'h05, 16'hABCD, 20'h5ABCC, 1'b1, 1'b1, 1'b0},
    {8'h0F, 16'hFFFF, 20'hFFFFF, 1'b1, 1'b0, 1'b0},
    {8'h0F, 16'hFFFF, 20'hFFFFF, 1'b0, 1'b1, 1'b0},
    {8'h0F, 16'hFFFF, 20'hFFFFF, 1'b1, 1'b1, 1'b1},
    {8'h08, 16'h0000, 20'h00000, 1'b1, 1'b1, 1'b0}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic roll_pulse();
    @(negedge clk);
    sub_roll = 1'b1;
    @(negedge clk);
    sub_roll = 1'b0;
  endtask

  initial begin
    #4_000_000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] r;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(2'd0, r); chk("R1 sub reg", r, 0);
    rd(2'd1, r); chk("R1 low reg", r, 0);
    rd(2'd2, r); chk("R1 high reg", r, 0);
    rd(2'd3, r); chk("R1 status", r, 0);
    chk("R1 reload out", sub_reload_val, 0);

    // Table walk: R4 R5 R6 R2
    for (int i = 0; i < 7; i++) begin
      alarm_en = 1'b0; clock_en = 1'b0;
      wr(2'd1, VEC[i][38:23]);
      wr(2'd2, {8'h00, VEC[i][46:39]});
      wr(2'd3, 16'h0007);
      rd(2'd2, r); chk("R2 high readback all 8 bits", r, {8'h00, VEC[i][46:39]});
      secs_low = VEC[i][22:3];
      alarm_en = VEC[i][2]; clock_en = VEC[i][1];
      roll_pulse();
      chk($sformatf("R4/R5/R6 vector %0d", i), tod_flag, VEC[i][0]);
    end
    alarm_en = 1'b0; clock_en = 1'b0;
    wr(2'd3, 16'h0007);

    // R2 / R7 subsecond register and reload output
    wr(2'd0, 16'hFFA5);
    rd(2'd0, r); chk("R2 sub readback", r, 16'h00A5);
    chk("R7 reload value out", sub_reload_val, 8'hA5);

    // R3 busy lock
    wr(2'd1, 16'h1111);
    clk_busy = 1'b1;
    wr(2'd1, 16'h2222);
    rd(2'd1, r); chk("R3 busy write ignored", r, 16'h1111);
    chk("R3 error set", wr_err, 1);
    clk_busy = 1'b0;
    // R9 sticky error
    repeat (3) @(negedge clk);
    chk("R9 error holds", wr_err, 1);
    wr(2'd3, 16'h0004);
    chk("R9 error cleared", wr_err, 0);

    // R3 both enables lock; one enable alone does not
    alarm_en = 1'b1; clock_en = 1'b1;
    wr(2'd2, 16'h00C3);
    rd(2'd2, r); chk("R3 enabled write ignored", r, 16'h0008);
    chk("R3 error set again", wr_err, 1);
    wr(2'd3, 16'h0004);
    clock_en = 1'b0;
    wr(2'd2, 16'h00C3);
    rd(2'd2, r); chk("R3 write with clock off", r, 16'h00C3);
    chk("R3 no error when open", wr_err, 0);

    // R6 equal value but no rollover
    wr(2'd1, 16'h4321);
    secs_low = 20'h34321;
    alarm_en = 1'b1; clock_en = 1'b1;
    repeat (4) @(negedge clk);
    chk("R6 no set without rollover", tod_flag, 0);
    // R4 timing: flag appears exactly after the rollover edge
    @(negedge clk); sub_roll = 1'b1;
    #1 chk("R4 not before edge", tod_flag, 0);
    @(negedge clk); sub_roll = 1'b0;
    chk("R4 set after edge", tod_flag, 1);

    // R8 clear alone, then set wins over clear
    wr(2'd3, 16'h0001);
    chk("R8 clear alone", tod_flag, 0);
    roll_pulse();
    chk("R8 set again", tod_flag, 1);
    @(negedge clk);
    sub_roll = 1'b1; reg_addr = 2'd3; reg_wdata = 16'h0001; reg_wr = 1'b1;
    @(negedge clk);
    sub_roll = 1'b0; reg_wr = 1'b0;
    chk("R8 set wins over clear", tod_flag, 1);
    secs_low = 20'h00000;
    @(negedge clk);
    sub_roll = 1'b1; reg_addr = 2'd3; reg_wdata = 16'h0001; reg_wr = 1'b1;
    @(negedge clk);
    sub_roll = 1'b0; reg_wr = 1'b0;
    chk("R8 clear with non-matching roll", tod_flag, 0);

    // R7 subsecond flag and status bit 1
    @(negedge clk); sub_reload = 1'b1;
    @(negedge clk); sub_reload = 1'b0;
    chk("R7 sub flag set", sub_flag, 1);
    rd(2'd3, r); chk("R8 status shows sub bit", r, 16'h0002);
    wr(2'd3, 16'h0002);
    chk("R8 sub flag cleared", sub_flag, 0);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule